// File: doc/BRIEF.md
# Two-Line Fully Associative Byte Cache

This block places a very small cache between a single load/store port and a byte-wide backing memory of sixteen locations. It holds two blocks of two bytes each. Any block may sit in either line, so a lookup compares the request tag against both lines in the same cycle. A single recency bit picks which line to replace on a miss. A build-time parameter sets the store policy. Write-through sends every store on to memory. Write-back keeps a dirty flag per line and only writes a modified block out when that block is evicted. Both policies allocate a line on a store miss.

The processor side raises `req_valid` for one cycle while the block is idle, with a 4-bit address, a store flag and a data byte. It then waits for the one-cycle `rsp_done` pulse, which carries load data on `rsp_rdata`. A missing `rsp_done` means the cache is still busy and new requests must wait. The memory side moves one byte per beat. A beat completes on a clock edge where `mem_req` and `mem_ready` are both high. Four free-running counters report hits, misses, memory reads and memory writes.

The controller has seven states. ST_IDLE waits for a request and latches it (IDLE→CHECK). ST_CHECK compares tags. On a hit it goes to APPLY. On a miss it goes to EVICT if write-back is selected and the victim line is valid and dirty, and to FILL otherwise. ST_EVICT writes the victim's bytes out (EVICT→FILL after the last beat). ST_FILL reads the requested block in (FILL→APPLY after the last beat). ST_APPLY performs the load or store and moves the recency bit. It then goes to WTHRU for a write-through store and to RESP otherwise. ST_WTHRU writes the stored byte to memory (WTHRU→RESP). ST_RESP pulses done (RESP→IDLE).

Top module: `byte_assoc_cache`

## Requirements
- R1: After reset all four counters read zero, `rsp_done` and `mem_req` are low, both lines are invalid, the recency bit names line 0, and the first access always misses.
- R2: Address bit 0 picks the byte within a block and bits 3:1 form the tag; a load returns the byte most recently stored to that address, or the memory byte if it was never stored.
- R3: An access hits only if a valid line holds the request tag; a hit adds one to the hit counter and, for loads and write-back stores, causes no memory traffic.
- R4: A miss adds one to the miss counter and reads both bytes of the requested block from memory (two memory reads), so the read counter is even whenever `rsp_done` is high.
- R5: The recency bit names the victim on a miss and, after every access (hit or miss), points at the line not just used.
- R6: A store miss first fills the block and then writes the byte into the filled line (write-allocate, both policies).
- R7: With write-through selected, every store writes its byte to memory once, adding one memory write, and memory holds the stored byte by the time `rsp_done` rises.
- R8: With write-back selected, a store changes only the cached byte and marks the line dirty; the memory byte keeps its old value.
- R9: With write-back selected, replacing a dirty line first writes both of its bytes back (two memory writes) before the fill; replacing a clean line writes nothing.
- R10: While `mem_req` is high and `mem_ready` is low, the memory address, write flag and write data stay unchanged on the next cycle.
- R11: A request is taken only in the idle state; `rsp_done` lasts exactly one cycle with no memory request active; a load hit, or a write-back store hit, raises `rsp_done` in the cycle after the third rising edge counted from the accepting edge.
- R12: Each counter steps by at most one per cycle; for the sequence load 1, load 7, store 0, store 5, load 10, store 5, store 10 from reset, the totals are 3 hits, 4 misses, 8 memory reads, and 4 memory writes (write-through) or 2 (write-back).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load result, valid with rsp_done |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_ready | input | 1 | Memory completes the beat this edge |
| mem_rdata | input | DATA_W | Memory read byte, valid with mem_ready |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |
| cnt_mrd | output | CNT_W | Memory read beats |
| cnt_mwr | output | CNT_W | Memory write beats |

## Verification
The bench builds two copies side by side with the default 4-bit address and 2-byte blocks. One has `WRITE_BACK` cleared and the other has it set, and both receive the same request stream. Each copy has its own memory model that stalls `mem_ready` at random, so one run covers write-through stores waiting on memory, dirty and clean evictions, and the recency bit choosing victims under both policies. The counter totals and the final memory images can then be compared per policy against a bench reference model.

// File: rtl/byte_cache_pkg.sv
package byte_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EVICT,
        ST_FILL,
        ST_APPLY,
        ST_WTHRU,
        ST_RESP
    } cache_state_e;

    localparam int CTR_HIT  = 0;
    localparam int CTR_MISS = 1;
    localparam int CTR_MRD  = 2;
    localparam int CTR_MWR  = 3;
    localparam int NUM_CTRS = 4;
endpackage

// File: rtl/byte_cache_match.sv
module byte_cache_match #(
    parameter int TAG_W = 3,
    parameter int LINES = 2,
    localparam int WAY_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0]            valid,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);
    logic [LINES-1:0] eq;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == tag);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (eq[i]) way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/byte_cache_counters.sv
module byte_cache_counters #(
    parameter int CNT_W = 16,
    parameter int NUM   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] count
);
    for (genvar g = 0; g < NUM; g++) begin : g_ctr
        logic [CNT_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)      q <= '0;
            else if (inc[g]) q <= q + 1'b1;
        end
        assign count[g] = q;
    end
endmodule

// File: rtl/byte_assoc_cache.sv
module byte_assoc_cache
    import byte_cache_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int OFFS_W     = 1,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_mrd,
    output logic [CNT_W-1:0]  cnt_mwr
);
    localparam int TAG_W = ADDR_W - OFFS_W;
    localparam int BLK   = 1 << OFFS_W;
    localparam int LINES = 2;
    localparam logic [OFFS_W-1:0] LAST_BEAT = OFFS_W'(BLK - 1);

    cache_state_e state, nstate;

    logic [LINES-1:0]            vld, dty;
    logic [LINES-1:0][TAG_W-1:0] ltag;
    logic [DATA_W-1:0]           ldat [LINES][BLK];
    logic                        lru, sel;

    logic              q_write;
    logic [TAG_W-1:0]  q_tag;
    logic [OFFS_W-1:0] q_off;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] rdata_q;
    logic [OFFS_W-1:0] beat;
    logic              beat_last;

    logic                         hit, hit_way;
    logic [NUM_CTRS-1:0]          inc;
    logic [NUM_CTRS-1:0][CNT_W-1:0] counts;

    assign beat_last = (beat == LAST_BEAT);

    byte_cache_match #(.TAG_W(TAG_W), .LINES(LINES)) u_match (
        .valid (vld),
        .tags  (ltag),
        .tag   (q_tag),
        .hit   (hit),
        .way   (hit_way)
    );

    byte_cache_counters #(.CNT_W(CNT_W), .NUM(NUM_CTRS)) u_ctrs (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .count (counts)
    );

    assign cnt_hit  = counts[CTR_HIT];
    assign cnt_miss = counts[CTR_MISS];
    assign cnt_mrd  = counts[CTR_MRD];
    assign cnt_mwr  = counts[CTR_MWR];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state and outputs
    always_comb begin
        nstate    = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rsp_done  = 1'b0;
        rsp_rdata = rdata_q;
        inc       = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nstate = ST_CHECK;
            end
            ST_CHECK: begin
                inc[CTR_HIT]  = hit;
                inc[CTR_MISS] = !hit;
                if (hit)                                      nstate = ST_APPLY;
                else if (WRITE_BACK && vld[lru] && dty[lru]) nstate = ST_EVICT;
                else                                          nstate = ST_FILL;
            end
            ST_EVICT: begin
                mem_req       = 1'b1;
                mem_we        = 1'b1;
                mem_addr      = {ltag[sel], beat};
                mem_wdata     = ldat[sel][beat];
                inc[CTR_MWR]  = mem_ready;
                if (mem_ready && beat_last) nstate = ST_FILL;
            end
            ST_FILL: begin
                mem_req       = 1'b1;
                mem_addr      = {q_tag, beat};
                inc[CTR_MRD]  = mem_ready;
                if (mem_ready && beat_last) nstate = ST_APPLY;
            end
            ST_APPLY: begin
                nstate = (q_write && !WRITE_BACK) ? ST_WTHRU : ST_RESP;
            end
            ST_WTHRU: begin
                mem_req       = 1'b1;
                mem_we        = 1'b1;
                mem_addr      = {q_tag, q_off};
                mem_wdata     = q_wdata;
                inc[CTR_MWR]  = mem_ready;
                if (mem_ready) nstate = ST_RESP;
            end
            ST_RESP: begin
                rsp_done = 1'b1;
                nstate   = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Control and tag state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld     <= '0;
            dty     <= '0;
            ltag    <= '0;
            lru     <= 1'b0;
            sel     <= 1'b0;
            beat    <= '0;
            q_write <= 1'b0;
            q_tag   <= '0;
            q_off   <= '0;
            q_wdata <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write <= req_write;
                        q_tag   <= req_addr[ADDR_W-1:OFFS_W];
                        q_off   <= req_addr[OFFS_W-1:0];
                        q_wdata <= req_wdata;
                    end
                end
                ST_CHECK: begin
                    sel  <= hit ? hit_way : lru;
                    beat <= '0;
                end
                ST_EVICT: begin
                    if (mem_ready) beat <= beat + 1'b1;
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        beat <= beat + 1'b1;
                        if (beat_last) begin
                            vld[sel]  <= 1'b1;
                            dty[sel]  <= 1'b0;
                            ltag[sel] <= q_tag;
                        end
                    end
                end
                ST_APPLY: begin
                    lru <= ~sel;
                    if (q_write) begin
                        if (WRITE_BACK) dty[sel] <= 1'b1;
                    end else begin
                        rdata_q <= ldat[sel][q_off];
                    end
                end
                ST_WTHRU, ST_RESP: ;
                default: ;
            endcase
        end
    end

    // Line data storage
    always_ff @(posedge clk) begin
        if (state == ST_FILL && mem_ready)
            ldat[sel][beat] <= mem_rdata;
        else if (state == ST_APPLY && q_write)
            ldat[sel][q_off] <= q_wdata;
    end
endmodule

// File: rtl/byte_assoc_cache_chk.sv
module byte_assoc_cache_chk #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [CNT_W-1:0]  cnt_hit,
    input logic [CNT_W-1:0]  cnt_miss,
    input logic [CNT_W-1:0]  cnt_mrd,
    input logic [CNT_W-1:0]  cnt_mwr
);
    a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r11_done_quiet_mem: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !mem_req);

    a_r3_hit_not_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hit != $past(cnt_hit)) |-> $stable(cnt_miss));

    a_r4_reads_paired: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (cnt_mrd[0] == 1'b0));

    a_r9_writes_paired: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!WRITE_BACK || (cnt_mwr[0] == 1'b0)));

    a_r12_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mwr - $past(cnt_mwr)) <= CNT_W'(1));
endmodule

bind byte_assoc_cache byte_assoc_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_done  (rsp_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cnt_hit   (cnt_hit),
    .cnt_miss  (cnt_miss),
    .cnt_mrd   (cnt_mrd),
    .cnt_mwr   (cnt_mwr)
);

// File: tb/test_byte_assoc_cache.sv
`timescale 1ns/1ps
module test_byte_assoc_cache;
    // index 0: write-through copy, index 1: write-back copy
    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_write;
    logic [3:0] req_addr;
    logic [7:0] req_wdata;

    logic [1:0]            rdone, mreq, mwe, mready;
    logic [1:0][7:0]       rrd, mwdata, mrdata;
    logic [1:0][3:0]       maddr;
    logic [1:0][3:0][15:0] cobs;

    logic [7:0] bmem [2][16];

    localparam logic [7:0] INIT [16] = '{8'd78, 8'd29, 8'd120, 8'd123, 8'd71, 8'd150, 8'd162, 8'd173,
                                         8'd18, 8'd21, 8'd33, 8'd28, 8'd19, 8'd200, 8'd210, 8'd225};

    int n_checks = 0;
    int n_err = 0;

    // reference model state
    bit         rv   [2][2];
    bit         rdt  [2][2];
    logic [2:0] rtg  [2][2];
    logic [7:0] rdat [2][2][2];
    bit         rlru [2];
    int         rcnt [2][4];
    logic [7:0] rmem [2][16];

    always #4 clk = ~clk;

    byte_assoc_cache #(.WRITE_BACK(1'b0)) i_byte_assoc_cache_wt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rdone[0]), .rsp_rdata(rrd[0]),
        .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdata[0]),
        .mem_ready(mready[0]), .mem_rdata(mrdata[0]),
        .cnt_hit(cobs[0][0]), .cnt_miss(cobs[0][1]), .cnt_mrd(cobs[0][2]), .cnt_mwr(cobs[0][3]));

    byte_assoc_cache #(.WRITE_BACK(1'b1)) i_byte_assoc_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rdone[1]), .rsp_rdata(rrd[1]),
        .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdata[1]),
        .mem_ready(mready[1]), .mem_rdata(mrdata[1]),
        .cnt_hit(cobs[1][0]), .cnt_miss(cobs[1][1]), .cnt_mrd(cobs[1][2]), .cnt_mwr(cobs[1][3]));

    // memory writes complete on the handshake edge
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++)
            if (mreq[k] && mready[k] && mwe[k]) bmem[k][maddr[k]] = mwdata[k];
    end

    // memory ready/data driven away from the active edge, random stalls
    initial begin
        mready = '0;
        mrdata = '0;
        forever begin
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                mready[k] = mreq[k] && ($urandom_range(0, 2) != 0);
                mrdata[k] = bmem[k][maddr[k]];
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            rlru[k] = 1'b0;
            for (int w = 0; w < 2; w++) begin rv[k][w] = 1'b0; rdt[k][w] = 1'b0; rtg[k][w] = '0; end
            for (int i = 0; i < 4; i++) rcnt[k][i] = 0;
        end
    endtask

    task automatic ref_step(input int k, input bit w, input logic [3:0] a, input logic [7:0] d,
                            output logic [7:0] rd, output bit hit);
        logic [2:0] tg;
        int s;
        tg = a[3:1];
        hit = 1'b0;
        s = 0;
        rd = '0;
        for (int y = 0; y < 2; y++)
            if (rv[k][y] && rtg[k][y] == tg) begin hit = 1'b1; s = y; end
        if (hit) rcnt[k][0]++;
        else begin
            rcnt[k][1]++;
            s = int'(rlru[k]);
            if (k == 1 && rv[k][s] && rdt[k][s]) begin
                rmem[k][{rtg[k][s], 1'b0}] = rdat[k][s][0];
                rmem[k][{rtg[k][s], 1'b1}] = rdat[k][s][1];
                rcnt[k][3] += 2;
            end
            rdat[k][s][0] = rmem[k][{tg, 1'b0}];
            rdat[k][s][1] = rmem[k][{tg, 1'b1}];
            rcnt[k][2] += 2;
            rv[k][s] = 1'b1;
            rtg[k][s] = tg;
            rdt[k][s] = 1'b0;
        end
        if (w) begin
            rdat[k][s][a[0]] = d;
            if (k == 1) rdt[k][s] = 1'b1;
            else begin rmem[k][a] = d; rcnt[k][3]++; end
        end else begin
            rd = rdat[k][s][a[0]];
        end
        rlru[k] = (s == 0);
    endtask

    task automatic access(input bit w, input logic [3:0] a, input logic [7:0] d);
        logic [7:0] exp_rd [2];
        bit         exp_hit [2];
        int         lat [2];
        logic [7:0] got_rd [2];
        bit [1:0]   got;
        int         n;
        string      pol;
        for (int k = 0; k < 2; k++) ref_step(k, w, a, d, exp_rd[k], exp_hit[k]);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        got = '0; n = 0;
        lat[0] = 0; lat[1] = 0; got_rd[0] = '0; got_rd[1] = '0;
        while (got != 2'b11 && n < 200) begin
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 2; k++)
                if (!got[k] && rdone[k]) begin got[k] = 1'b1; lat[k] = n; got_rd[k] = rrd[k]; end
            n++;
        end
        chk(got == 2'b11, "R11 done pulse arrives", int'(got), 3);
        for (int k = 0; k < 2; k++) begin
            pol = (k == 1) ? "wb" : "wt";
            if (!w) chk(got_rd[k] == exp_rd[k], {"R2 load data ", pol}, got_rd[k], exp_rd[k]);
            if (exp_hit[k] && (!w || k == 1))
                chk(lat[k] == 2, {"R11 hit latency ", pol}, lat[k], 2);
            chk(cobs[k][0] == rcnt[k][0], {"R3 hit count ", pol}, cobs[k][0], rcnt[k][0]);
            chk(cobs[k][1] == rcnt[k][1], {"R4 miss count ", pol}, cobs[k][1], rcnt[k][1]);
            chk(cobs[k][2] == rcnt[k][2], {"R4 read beats ", pol}, cobs[k][2], rcnt[k][2]);
            chk(cobs[k][3] == rcnt[k][3], {(k == 1) ? "R9 write beats wb" : "R7 write beats wt"},
                cobs[k][3], rcnt[k][3]);
        end
        if (w) begin
            chk(bmem[0][a] == d, "R7 memory holds stored byte", bmem[0][a], d);
            chk(bmem[1][a] == rmem[1][a], "R8 memory untouched by store", bmem[1][a], rmem[1][a]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL R11 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int h0 [2];
        int m0 [2];
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 16; i++) begin bmem[k][i] = INIT[i]; rmem[k][i] = INIT[i]; end
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 4; i++) chk(cobs[k][i] == 0, "R1 counter cleared", cobs[k][i], 0);
            chk(rdone[k] == 1'b0, "R1 done low", rdone[k], 0);
            chk(mreq[k] == 1'b0, "R1 no memory request", mreq[k], 0);
        end

        // R12 directed policy sequence
        access(1'b0, 4'd1, 8'd0);
        chk(cobs[0][1] == 1 && cobs[1][1] == 1, "R1 first access misses", cobs[1][1], 1);
        access(1'b0, 4'd7, 8'd0);
        access(1'b1, 4'd0, 8'd173);
        access(1'b1, 4'd5, 8'd29);
        chk(cobs[1][3] == 0, "R9 clean eviction writes nothing", cobs[1][3], 0);
        chk(bmem[0][5] == 8'd29, "R6 store miss allocates and writes", bmem[0][5], 29);
        access(1'b0, 4'd10, 8'd0);
        access(1'b1, 4'd5, 8'd29);
        access(1'b1, 4'd10, 8'd29);
        for (int k = 0; k < 2; k++) begin
            chk(cobs[k][0] == 3, "R12 total hits", cobs[k][0], 3);
            chk(cobs[k][1] == 4, "R12 total misses", cobs[k][1], 4);
            chk(cobs[k][2] == 8, "R12 total reads", cobs[k][2], 8);
        end
        chk(cobs[0][3] == 4, "R12 total writes wt", cobs[0][3], 4);
        chk(cobs[1][3] == 2, "R12 total writes wb", cobs[1][3], 2);
        chk(bmem[1][0] == 8'd173, "R9 dirty block written back", bmem[1][0], 173);

        // R5 recency: tags 6, 7, 6(hit), 0 evicts 7, then 6 hits and 7 misses
        access(1'b0, 4'd12, 8'd0);
        access(1'b0, 4'd14, 8'd0);
        access(1'b0, 4'd13, 8'd0);
        access(1'b0, 4'd0, 8'd0);
        for (int k = 0; k < 2; k++) begin h0[k] = cobs[k][0]; m0[k] = cobs[k][1]; end
        access(1'b0, 4'd12, 8'd0);
        for (int k = 0; k < 2; k++) chk(cobs[k][0] == h0[k] + 1, "R5 recent line kept", cobs[k][0], h0[k] + 1);
        access(1'b0, 4'd15, 8'd0);
        for (int k = 0; k < 2; k++) chk(cobs[k][1] == m0[k] + 1, "R5 older line evicted", cobs[k][1], m0[k] + 1);

        // constrained random mix, biased to a few tags to raise the hit rate
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            a = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 5));
            access(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
        end

        for (int i = 0; i < 16; i++) begin
            chk(bmem[0][i] == rmem[0][i], "R7 final memory wt", bmem[0][i], rmem[0][i]);
            chk(bmem[1][i] == rmem[1][i], "R9 final memory wb", bmem[1][i], rmem[1][i]);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule